// File: doc/BRIEF.md
# Oscillator Warm-up and PLL Lock Timer

This block measures a programmable settling interval that begins when the high-speed oscillator is switched on. A single counter provides both intervals. The warm-up interval ends with a one-cycle done pulse. The counter then keeps running until the longer lock-up interval ends. A pending flag, which software polls, stays high from the start of counting until the lock-up interval has run out. Settling is modelled only as a number of elapsed cycles of the input clock. No oscillator or phase detector is modelled.

Software programs both intervals through a small write port. The block keeps the lock-up count at least as large as the warm-up count, so that lock-up cannot finish before warm-up. A new oscillator-start pulse at any time restarts the count from zero. While the PLL is disabled the pending flag reads 0.

Top module: `osc_settle_timer`

## Requirements
- R1: After reset, `warm_done` and `lock_pending` are 0, and no count is running.
- R2: Let E0 be the clock edge that samples `osc_start` high. With `pll_en` high, `lock_pending` reads 1 from E0 until the edge L cycles after E0, where L is the effective lock-up count. From that edge on it reads 0.
- R3: `warm_done` is high for exactly one cycle, following the edge W cycles after E0, where W is the effective warm-up count. It is 0 at every other time.
- R4: When a write supplies a lock-up count below the effective warm-up count, the effective lock-up count equals the effective warm-up count.
- R5: When a write supplies a warm-up count of 0, the effective warm-up count is 1.
- R6: A start pulse during counting restarts the count from zero and sets the pending flag again. Both outputs then follow R2 and R3, measured from the new start edge.
- R7: While `pll_en` is 0, `lock_pending` reads 0. The count still runs and `warm_done` still pulses. Raising `pll_en` during counting shows the pending state again.
- R8: After reset the effective lock-up count is 65536 cycles (2^16) and the effective warm-up count is the `WARM_RST` parameter (default 16384).
- R9: Once lock-up completes, no further `warm_done` pulse occurs and the flag stays 0 until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counting is in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_start | input | 1 | One-cycle pulse: oscillator switched on, (re)start counting |
| pll_en | input | 1 | PLL in use; when 0 the pending flag reads 0 |
| cfg_we | input | 1 | Write strobe for the two interval counts |
| cfg_warm | input | 17 | Warm-up count to write (0 means 1) |
| cfg_lock | input | 17 | Lock-up count to write (raised to warm-up if lower) |
| warm_done | output | 1 | One-cycle pulse when warm-up has elapsed |
| lock_pending | output | 1 | 1 while lock-up is still being timed |

## Verification
The checker evaluates several rules on every cycle. The stored lock-up count never falls below the warm-up count, and the warm-up count is never zero. `warm_done` is never high on two consecutive cycles. A start pulse always leaves the count at zero, with the flag set when the PLL is enabled. An idle counter never produces a pulse. The bench scenarios are needed for the exact cycle on which the pulse and the flag change, for the clamping of written values as seen at the outputs, for a restart during counting, for toggling of `pll_en`, and for the 2^16 default after reset.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;

    parameter int unsigned CNT_W = 17;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t warm;
        cnt_t lock;
    } settle_cfg_t;

    typedef struct packed {
        cnt_t cnt;
        logic run;
        logic pend;
        logic pulse;
    } settle_cnt_t;

    // Warm-up of zero becomes one; lock-up never below warm-up.
    function automatic settle_cfg_t settle_clamp(cnt_t warm_in, cnt_t lock_in);
        settle_cfg_t r;
        r.warm = (warm_in == '0) ? cnt_t'(1) : warm_in;
        r.lock = (lock_in < r.warm) ? r.warm : lock_in;
        return r;
    endfunction

endpackage

// File: rtl/osc_settle_cfg.sv
module osc_settle_cfg
    import osc_settle_pkg::*;
#(
    parameter cnt_t WARM_RST = cnt_t'(16384),
    parameter cnt_t LOCK_RST = cnt_t'(65536)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  cnt_t warm_in,
    input  cnt_t lock_in,
    output cnt_t warm_o,
    output cnt_t lock_o
);

    localparam settle_cfg_t CFG_RST = settle_clamp(WARM_RST, LOCK_RST);

    settle_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = settle_clamp(warm_in, lock_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign warm_o = cfg_q.warm;
    assign lock_o = cfg_q.lock;

endmodule

// File: rtl/osc_settle_cnt.sv
module osc_settle_cnt
    import osc_settle_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  cnt_t warm_lim,
    input  cnt_t lock_lim,
    output cnt_t cnt_o,
    output logic run_o,
    output logic pend_o,
    output logic pulse_o
);

    localparam settle_cnt_t ST_RST = '{cnt: '0, run: 1'b0, pend: 1'b0, pulse: 1'b0};

    settle_cnt_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (st_q.run) begin
            st_d.cnt = st_q.cnt + cnt_t'(1);
            if (st_d.cnt == warm_lim) begin
                st_d.pulse = 1'b1;
            end
            // >= keeps the count bounded if the limit is rewritten lower mid-count
            if (st_d.cnt >= lock_lim) begin
                st_d.run  = 1'b0;
                st_d.pend = 1'b0;
            end
        end
        if (start) begin
            st_d.cnt   = '0;
            st_d.run   = 1'b1;
            st_d.pend  = 1'b1;
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign run_o   = st_q.run;
    assign pend_o  = st_q.pend;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
    import osc_settle_pkg::*;
#(
    parameter cnt_t WARM_RST = cnt_t'(16384),
    parameter cnt_t LOCK_RST = cnt_t'(65536)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_start,
    input  logic             pll_en,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_warm,
    input  logic [CNT_W-1:0] cfg_lock,
    output logic             warm_done,
    output logic             lock_pending
);

    cnt_t warm_q;
    cnt_t lock_q;
    cnt_t cnt_q;
    logic run_q;
    logic pend_q;

    osc_settle_cfg #(
        .WARM_RST (WARM_RST),
        .LOCK_RST (LOCK_RST)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .warm_in (cfg_warm),
        .lock_in (cfg_lock),
        .warm_o  (warm_q),
        .lock_o  (lock_q)
    );

    osc_settle_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (osc_start),
        .warm_lim (warm_q),
        .lock_lim (lock_q),
        .cnt_o    (cnt_q),
        .run_o    (run_q),
        .pend_o   (pend_q),
        .pulse_o  (warm_done)
    );

    // Flag is defined as 0 whenever the PLL is not in use.
    assign lock_pending = pll_en & pend_q;

endmodule

// File: rtl/osc_settle_chk.sv
module osc_settle_chk
    import osc_settle_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic osc_start,
    input logic pll_en,
    input logic warm_done,
    input logic lock_pending,
    input cnt_t warm_q,
    input cnt_t lock_q,
    input cnt_t cnt_q,
    input logic run_q
);

    a_r4_lock_ge_warm: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q >= warm_q);

    a_r5_warm_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q != '0);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        warm_done |=> !warm_done);

    a_r2_start_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        osc_start |=> (pll_en |-> lock_pending));

    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        osc_start |=> (run_q && cnt_q == '0));

    a_r9_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !osc_start) |=> !warm_done);

endmodule

bind osc_settle_timer osc_settle_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_start    (osc_start),
    .pll_en       (pll_en),
    .warm_done    (warm_done),
    .lock_pending (lock_pending),
    .warm_q       (warm_q),
    .lock_q       (lock_q),
    .cnt_q        (cnt_q),
    .run_q        (run_q)
);

// File: tb/sim_osc_settle_timer.sv
`timescale 1ns/1ps
module sim_osc_settle_timer;

    localparam int CW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_start = 1'b0;
    logic          pll_en = 1'b1;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_warm = '0;
    logic [CW-1:0] cfg_lock = '0;
    logic          warm_done;
    logic          lock_pending;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    osc_settle_timer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_start    (osc_start),
        .pll_en       (pll_en),
        .cfg_we       (cfg_we),
        .cfg_warm     (cfg_warm),
        .cfg_lock     (cfg_lock),
        .warm_done    (warm_done),
        .lock_pending (lock_pending)
    );

    function automatic int eff_warm(int w);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic int eff_lock(int w, int l);
        return (l < eff_warm(w)) ? eff_warm(w) : l;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input int k);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at k=%0d: actual=%0b expected=%0b", tag, k, act, exp);
        end
    endtask

    task automatic write_cfg(input int w, input int l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_warm = CW'(w); cfg_lock = CW'(l);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Leaves the bench at the negedge right after the start edge (k = 0).
    task automatic pulse_start();
        @(negedge clk);
        osc_start = 1'b1;
        @(negedge clk);
        osc_start = 1'b0;
    endtask

    // Checks k = 0..last after a start; rnd_pll toggles pll_en randomly (R7).
    task automatic watch(input int w, input int l, input int last, input bit rnd_pll, input string tag);
        for (int k = 0; k <= last; k++) begin
            if (k > 0) @(negedge clk);
            if (rnd_pll) pll_en = 1'($urandom_range(0, 1));
            #1;
            chk(warm_done, (k == w), {tag, " R3 warm_done"}, k);
            chk(lock_pending, pll_en && (k < l), {tag, " R2 lock_pending"}, k);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(warm_done, 1'b0, "R1 reset warm_done", 0);
        chk(lock_pending, 1'b0, "R1 reset lock_pending", 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(lock_pending, 1'b0, "R1 idle lock_pending", 0);

        // R8: defaults 16384 / 65536, R9 checked past the end
        pulse_start();
        watch(16384, 65536, 65540, 1'b0, "R8 default");

        // R4: lock below warm clamps up
        write_cfg(20, 7);
        pulse_start();
        watch(20, 20, 25, 1'b0, "R4 clamp");

        // R5: warm of zero acts as one
        write_cfg(0, 6);
        pulse_start();
        watch(1, 6, 10, 1'b0, "R5 zero warm");

        // R6: restart mid-count
        write_cfg(5, 20);
        pulse_start();
        watch(5, 20, 8, 1'b0, "R6 first run");
        pulse_start();
        watch(5, 20, 24, 1'b0, "R6 restarted");

        // R7: PLL disabled: flag 0, pulse still occurs
        pll_en = 1'b0;
        write_cfg(4, 12);
        pulse_start();
        watch(4, 12, 15, 1'b0, "R7 pll off");
        pll_en = 1'b1;

        // Random intervals with random PLL enable (R2, R3, R4, R5, R7, R9)
        for (int n = 0; n < 40; n++) begin
            int w, l;
            w = $urandom_range(0, 40);
            l = $urandom_range(0, 60);
            write_cfg(w, l);
            pulse_start();
            watch(eff_warm(w), eff_lock(w, l), eff_lock(w, l) + 3, 1'b1, "rand");
        end
        pll_en = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule